// File: doc/BRIEF.md
# Tiled DMA-Compute Pipeline Scheduler

This block takes composite commands from a submission queue and runs them tile by tile. It drives three engines: an input read DMA channel, one compute engine and an output write DMA channel. Each engine can hold one operation at a time. Each engine appears only as a start/done handshake. Every tile passes through its read, then its compute, then its write. Work from neighbouring tiles overlaps wherever the engines and the buffer limit allow.

A command carries an identifier, a compute opcode and a tile count. The compute opcode is either matrix multiply or elementwise math. Both opcodes use the single compute slot. The block handles one command at a time. When the final tile's write has finished, it posts a completion carrying the identifier and an error flag. Only after that can a new command be taken. Two kinds of command finish at once without touching any engine: a command with no tiles, and a command with an opcode that is not recognised.

Top module: `tile_pipe_sched`

## Requirements
- R1: While reset is held (synchronous, active low), and in the first cycle after release, `sub_ready` is 1, `cpl_valid` is 0 and no engine start is asserted.
- R2: For every tile, compute starts only after that tile's read done has been seen. The tile's write starts only after its compute done has been seen.
- R3: Each engine receives at most one start until it returns done. Every start is a single-cycle pulse.
- R4: For a command of N tiles, each engine is started exactly N times. The tile index it receives counts 0, 1, ..., N-1 in order.
- R5: No more than two tiles are in flight. The read of tile t+2 does not start before the write done of tile t.
- R6: The read of tile t+1 starts as soon as the read channel is free, so it can overlap the compute of tile t. Reads, compute and writes of different tiles run at the same time.
- R7: Opcode encoding on `sub_op`: 2'b01 is GEMM and 2'b10 is MATH. For every compute start, `cmp_op` shows the command's opcode: 0 for GEMM and 1 for MATH.
- R8: After the final tile's write done, `cpl_valid` pulses for exactly one cycle, two cycles after the done cycle, with `cpl_id` equal to the command's identifier and `cpl_err` equal to 0.
- R9: A command with a tile count of 0 posts its completion (`cpl_err` = 0) in the cycle right after acceptance and starts no engine.
- R10: Opcodes 2'b00 and 2'b11 are not executed. They start no engine and post a completion with `cpl_err` = 1 in the cycle right after acceptance.
- R11: Commands are served one at a time in arrival order. `sub_ready` is 0 from the cycle after acceptance through the completion cycle, and it returns to 1 in the cycle after completion.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_valid | input | 1 | Submission queue has a command |
| sub_ready | output | 1 | Block takes the command this cycle |
| sub_id | input | ID_W | Command identifier |
| sub_op | input | 2 | Compute opcode (01 GEMM, 10 MATH) |
| sub_tiles | input | TILE_W | Number of tiles |
| rd_start | output | 1 | Start pulse to the read DMA channel |
| rd_tile | output | TILE_W | Tile index for the read |
| rd_done | input | 1 | Read finished |
| cmp_start | output | 1 | Start pulse to the compute engine |
| cmp_op | output | 1 | 0 GEMM, 1 MATH |
| cmp_tile | output | TILE_W | Tile index for the compute |
| cmp_done | input | 1 | Compute finished |
| wr_start | output | 1 | Start pulse to the write DMA channel |
| wr_tile | output | TILE_W | Tile index for the write |
| wr_done | input | 1 | Write finished |
| cpl_valid | output | 1 | Completion entry, one-cycle pulse |
| cpl_id | output | ID_W | Identifier of the completed command |
| cpl_err | output | 1 | 1 when the opcode was rejected |

## Verification
The assertions take for granted that an engine raises done only while it holds an operation, as a one-cycle pulse, and at the earliest one cycle after its start. They also assume `sub_valid` is held until `sub_ready` accepts it. The engine models in the bench keep to these rules: each answers a start after a latency of at least one cycle, which is set per command, and never raises done otherwise. The driver raises `sub_valid` only when `sub_ready` is seen high, so every command is taken in the next edge.

// File: rtl/tps_pkg.sv
// Shared definitions for the tiled pipeline scheduler.
// Assumes opcodes arrive as a 2-bit field; only two codes are legal.
package tps_pkg;
    localparam logic [1:0] OP_GEMM = 2'b01;
    localparam logic [1:0] OP_MATH = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_POST = 2'd2
    } sched_st_e;

    localparam int ENG_RD  = 0;
    localparam int ENG_CMP = 1;
    localparam int ENG_WR  = 2;
    localparam int N_ENG   = 3;
endpackage

// File: rtl/tps_chan.sv
// One capacity-one engine slot: issues a registered start pulse when
// allowed and idle, tracks busy, and counts issued and finished tiles.
// Assumes done arrives only while busy, as a one-cycle pulse.
module tps_chan #(
    parameter int TILE_W = 6,
    parameter int CNT_W  = TILE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              allow,
    input  logic              done_i,
    output logic              start_o,
    output logic [TILE_W-1:0] tile_o,
    output logic [CNT_W-1:0]  iss_cnt,
    output logic [CNT_W-1:0]  done_cnt
);
    logic busy;

    // Issue, busy tracking and counters for this engine.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy     <= 1'b0;
            start_o  <= 1'b0;
            tile_o   <= '0;
            iss_cnt  <= '0;
            done_cnt <= '0;
        end else begin
            start_o <= 1'b0;
            if (allow && !busy) begin
                start_o <= 1'b1;
                busy    <= 1'b1;
                tile_o  <= iss_cnt[TILE_W-1:0];
                iss_cnt <= iss_cnt + 1'b1;
            end else if (busy && done_i) begin
                busy     <= 1'b0;
                done_cnt <= done_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tps_cmd_fsm.sv
// Command sequencer: takes one command, decides run/immediate completion,
// and posts the completion once every write is done.
// Assumes the channel counters are cleared on the acceptance cycle.
module tps_cmd_fsm
    import tps_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int TILE_W = 6,
    parameter int CNT_W  = TILE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_valid,
    input  logic [ID_W-1:0]   sub_id,
    input  logic [1:0]        sub_op,
    input  logic [TILE_W-1:0] sub_tiles,
    input  logic [CNT_W-1:0]  wr_fin,
    output logic              sub_ready,
    output logic              accept,
    output logic              run,
    output logic [CNT_W-1:0]  tiles,
    output logic              is_math,
    output logic              cpl_valid,
    output logic [ID_W-1:0]   cpl_id,
    output logic              cpl_err
);
    sched_st_e state;
    logic      bad_op;

    assign bad_op    = (sub_op != OP_GEMM) && (sub_op != OP_MATH);
    assign sub_ready = (state == ST_IDLE);
    assign accept    = sub_valid && sub_ready;
    assign run       = (state == ST_RUN);
    assign cpl_valid = (state == ST_POST);

    // Command state and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tiles   <= '0;
            is_math <= 1'b0;
            cpl_id  <= '0;
            cpl_err <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (sub_valid) begin
                    cpl_id  <= sub_id;
                    is_math <= (sub_op == OP_MATH);
                    cpl_err <= bad_op;
                    tiles   <= bad_op ? '0 : CNT_W'(sub_tiles);
                    state   <= (bad_op || sub_tiles == '0) ? ST_POST : ST_RUN;
                end
                ST_RUN:  if (wr_fin == tiles) state <= ST_POST;
                ST_POST: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tile_pipe_sched.sv
// Top of the tiled DMA-compute scheduler: one command at a time, three
// capacity-one engines, at most MAX_LIVE tiles resident in local buffers.
// Assumes engines return done only for an outstanding start.
module tile_pipe_sched
    import tps_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int TILE_W   = 6,
    parameter int MAX_LIVE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_valid,
    output logic              sub_ready,
    input  logic [ID_W-1:0]   sub_id,
    input  logic [1:0]        sub_op,
    input  logic [TILE_W-1:0] sub_tiles,
    output logic              rd_start,
    output logic [TILE_W-1:0] rd_tile,
    input  logic              rd_done,
    output logic              cmp_start,
    output logic              cmp_op,
    output logic [TILE_W-1:0] cmp_tile,
    input  logic              cmp_done,
    output logic              wr_start,
    output logic [TILE_W-1:0] wr_tile,
    input  logic              wr_done,
    output logic              cpl_valid,
    output logic [ID_W-1:0]   cpl_id,
    output logic              cpl_err
);
    localparam int CNT_W = TILE_W + 2;

    logic              accept, run, is_math;
    logic [CNT_W-1:0]  tiles;
    logic [N_ENG-1:0]  allow, done_v, start_v;
    logic [CNT_W-1:0]  iss   [N_ENG];
    logic [CNT_W-1:0]  fin   [N_ENG];
    logic [TILE_W-1:0] tl    [N_ENG];

    tps_cmd_fsm #(.ID_W(ID_W), .TILE_W(TILE_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sub_valid(sub_valid), .sub_id(sub_id), .sub_op(sub_op),
        .sub_tiles(sub_tiles), .wr_fin(fin[ENG_WR]),
        .sub_ready(sub_ready), .accept(accept), .run(run),
        .tiles(tiles), .is_math(is_math),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_err(cpl_err)
    );

    // Gating per engine: reads bounded by tile count and buffer residency,
    // compute and write each trail the previous stage's finished count.
    always_comb begin
        allow[ENG_RD]  = run && (iss[ENG_RD] < tiles)
                             && (iss[ENG_RD] < fin[ENG_WR] + CNT_W'(MAX_LIVE));
        allow[ENG_CMP] = run && (iss[ENG_CMP] < fin[ENG_RD]);
        allow[ENG_WR]  = run && (iss[ENG_WR] < fin[ENG_CMP]);
    end

    assign done_v = {wr_done, cmp_done, rd_done};

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        tps_chan #(.TILE_W(TILE_W), .CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .clr(accept),
            .allow(allow[e]), .done_i(done_v[e]),
            .start_o(start_v[e]), .tile_o(tl[e]),
            .iss_cnt(iss[e]), .done_cnt(fin[e])
        );
    end

    assign rd_start  = start_v[ENG_RD];
    assign cmp_start = start_v[ENG_CMP];
    assign wr_start  = start_v[ENG_WR];
    assign rd_tile   = tl[ENG_RD];
    assign cmp_tile  = tl[ENG_CMP];
    assign wr_tile   = tl[ENG_WR];
    assign cmp_op    = is_math;
endmodule

// File: rtl/tps_sva.sv
// Checker for tile_pipe_sched: tracks starts and dones per engine at the
// ports and checks ordering, capacity and command sequencing.
// Assumes done pulses only answer outstanding starts.
module tps_sva (
    input logic clk,
    input logic rst_n,
    input logic sub_valid,
    input logic sub_ready,
    input logic rd_start,
    input logic rd_done,
    input logic cmp_start,
    input logic cmp_done,
    input logic wr_start,
    input logic wr_done,
    input logic cpl_valid
);
    logic [16:0] rs, rdn, cs, cdn, ws, wdn;

    // Running counts of starts and dones per engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs <= '0; rdn <= '0; cs <= '0; cdn <= '0; ws <= '0; wdn <= '0;
        end else begin
            rs  <= rs  + 17'(rd_start);
            rdn <= rdn + 17'(rd_done);
            cs  <= cs  + 17'(cmp_start);
            cdn <= cdn + 17'(cmp_done);
            ws  <= ws  + 17'(wr_start);
            wdn <= wdn + 17'(wr_done);
        end
    end

    AST_RD_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) rd_start |-> rs == rdn);   // R3
    AST_CMP_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) cmp_start |-> cs == cdn);  // R3
    AST_WR_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> ws == wdn);   // R3
    AST_CMP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) cmp_start |-> cs < rdn);   // R2
    AST_WR_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> ws < cdn);    // R2
    AST_RESIDENCY:    assert property (@(posedge clk) disable iff (!rst_n) rd_start |-> rs < wdn + 17'd2); // R5
    AST_CPL_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) cpl_valid |=> !cpl_valid); // R8
    AST_HOLD_OFF:     assert property (@(posedge clk) disable iff (!rst_n) (sub_valid && sub_ready) |=> !sub_ready); // R11
    AST_CPL_BLOCKS:   assert property (@(posedge clk) disable iff (!rst_n) cpl_valid |-> !sub_ready); // R11
    AST_QUIET_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) sub_ready |-> !(rd_start || cmp_start || wr_start)); // R9
endmodule

bind tile_pipe_sched tps_sva u_sva (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .rd_start(rd_start), .rd_done(rd_done), .cmp_start(cmp_start),
    .cmp_done(cmp_done), .wr_start(wr_start), .wr_done(wr_done),
    .cpl_valid(cpl_valid)
);

// File: tb/tile_pipe_sched_tb_top.sv
// Scoreboard bench: the driver pushes expected completions, engine models
// answer starts, a monitor pops and compares completions.
module tile_pipe_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_valid = 1'b0;
    logic       sub_ready;
    logic [3:0] sub_id = '0;
    logic [1:0] sub_op = '0;
    logic [5:0] sub_tiles = '0;
    logic       rd_start, cmp_start, wr_start, cmp_op;
    logic [5:0] rd_tile, cmp_tile, wr_tile;
    logic       rd_done, cmp_done, wr_done;
    logic       cpl_valid, cpl_err;
    logic [3:0] cpl_id;

    logic       start_v [3];
    logic [5:0] tile_v  [3];
    logic       done_v  [3];
    int         lat     [3];
    int         st_cnt  [3];
    int         dn_cnt  [3];
    logic       busy_e  [3];
    int         cyc = 0, total = 0, fails = 0, last_wr_cyc = 0;
    logic       cur_math = 1'b0, overlap_seen = 1'b0;

    typedef struct { logic [3:0] id; logic err; logic imm; int acc; int tiles; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tile_pipe_sched dut_i (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
        .sub_id(sub_id), .sub_op(sub_op), .sub_tiles(sub_tiles),
        .rd_start(rd_start), .rd_tile(rd_tile), .rd_done(rd_done),
        .cmp_start(cmp_start), .cmp_op(cmp_op), .cmp_tile(cmp_tile), .cmp_done(cmp_done),
        .wr_start(wr_start), .wr_tile(wr_tile), .wr_done(wr_done),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_err(cpl_err)
    );

    assign start_v[0] = rd_start;  assign start_v[1] = cmp_start; assign start_v[2] = wr_start;
    assign tile_v[0]  = rd_tile;   assign tile_v[1]  = cmp_tile;  assign tile_v[2]  = wr_tile;
    assign rd_done = done_v[0];    assign cmp_done = done_v[1];   assign wr_done = done_v[2];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Engine models: answer each start with done after lat[e] cycles.
    for (genvar e = 0; e < 3; e++) begin : g_eng
        initial begin
            done_v[e] = 1'b0; busy_e[e] = 1'b0;
            forever begin
                @(negedge clk);
                if (rst_n && start_v[e]) begin
                    chk(tile_v[e] == 6'(st_cnt[e]), "R4", "tile index", int'(tile_v[e]), st_cnt[e]);
                    if (e == 0) begin
                        chk(st_cnt[0] < dn_cnt[2] + 2, "R5", "reads ahead of writes", st_cnt[0], dn_cnt[2] + 1);
                        if (busy_e[1]) overlap_seen = 1'b1;
                    end
                    if (e == 1) begin
                        chk(st_cnt[1] < dn_cnt[0], "R2", "compute before read done", st_cnt[1], dn_cnt[0] - 1);
                        chk(cmp_op == cur_math, "R7", "cmp_op", int'(cmp_op), int'(cur_math));
                    end
                    if (e == 2)
                        chk(st_cnt[2] < dn_cnt[1], "R2", "write before compute done", st_cnt[2], dn_cnt[1] - 1);
                    busy_e[e] = 1'b1;
                    st_cnt[e]++;
                    for (int k = 1; k < lat[e]; k++) begin
                        @(negedge clk);
                        chk(!start_v[e], "R3", "start while busy", int'(start_v[e]), 0);
                    end
                    done_v[e] = 1'b1;
                    if (e == 2) last_wr_cyc = cyc;
                    @(negedge clk);
                    done_v[e] = 1'b0;
                    busy_e[e] = 1'b0;
                    dn_cnt[e]++;
                end
            end
        end
    end

    // Monitor: pop the expected completion and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpl_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected completion", 1, 0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    chk(cpl_id == x.id, "R8", "cpl_id", int'(cpl_id), int'(x.id));
                    chk(cpl_err == x.err, "R10", "cpl_err", int'(cpl_err), int'(x.err));
                    for (int e = 0; e < 3; e++)
                        chk(st_cnt[e] == x.tiles, "R4", "starts per engine", st_cnt[e], x.tiles);
                    if (x.imm) chk(cyc == x.acc, "R9", "immediate completion cycle", cyc, x.acc);
                    else       chk(cyc == last_wr_cyc + 2, "R8", "completion cycle", cyc, last_wr_cyc + 2);
                end
            end
        end
    end

    // Driver: wait for ready, push the expected entry, present the command.
    task automatic send(input logic [3:0] id, input logic [1:0] op, input int n,
                        input int lr, input int lc, input int lw);
        exp_t x;
        while (!sub_ready) @(negedge clk);
        lat[0] = lr; lat[1] = lc; lat[2] = lw;
        for (int e = 0; e < 3; e++) begin st_cnt[e] = 0; dn_cnt[e] = 0; end
        cur_math = (op == 2'b10);
        x.id = id; x.err = !(op == 2'b01 || op == 2'b10);
        x.imm = x.err || n == 0; x.acc = cyc + 1; x.tiles = x.err ? 0 : n;
        q.push_back(x);
        sub_valid = 1'b1; sub_id = id; sub_op = op; sub_tiles = 6'(n);
        @(negedge clk);
        sub_valid = 1'b0;
        chk(!sub_ready, "R11", "ready after accept", int'(sub_ready), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sub_ready == 1'b1, "R1", "ready in reset", int'(sub_ready), 1);
        chk(!cpl_valid && !rd_start && !cmp_start && !wr_start, "R1", "outputs in reset", int'(cpl_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sub_ready == 1'b1 && !cpl_valid, "R1", "state after reset", int'(sub_ready), 1);
        send(4'h1, 2'b01, 1, 2, 2, 2);
        send(4'h2, 2'b10, 4, 1, 1, 1);
        send(4'h3, 2'b01, 6, 1, 5, 1);
        send(4'h4, 2'b10, 5, 1, 1, 6);
        send(4'h5, 2'b01, 0, 1, 1, 1);
        send(4'h6, 2'b00, 3, 1, 1, 1);
        send(4'h7, 2'b11, 2, 1, 1, 1);
        send(4'h8, 2'b10, 0, 1, 1, 1);
        send(4'h9, 2'b01, 3, 4, 2, 3);
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(overlap_seen, "R6", "read overlapped compute", int'(overlap_seen), 1);
        chk(sub_ready == 1'b1, "R11", "ready after last completion", int'(sub_ready), 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule